// File: doc/BRIEF.md
# Flow-Control Credit Update Scheduler

This block sits in a serial-link receiver and keeps the books for one credit class of its receive buffer. It counts header and data credits that arriving packets use up, and credits that the local consumer hands back. From these counts it decides when a flow-control update has to go out to the far end. It also decides whether that update is urgent. Data credits are counted in 16-byte units. Header credits are counted per packet.

The update leaves through a valid/ready channel. The block raises `upd_valid` and carries the priority flag and both credit limits on the same cycle. Once `upd_valid` is high, it stays high and the payload stays frozen until `upd_ready` is seen high at a rising clock edge. The consumer may hold `upd_ready` low for as long as it likes. Credits that are freed in the meantime are kept and go out with the next update. The handshake cycle itself makes the sent limits the new baseline. The `upd_idle` pin is a plain status output. Power-management logic uses it to confirm that no urgent credit work remains before the link enters a low-power state.

An update is urgent in three cases:
- the update timer runs out while no credit has been freed since the last update;
- the far end has used up every header credit it was granted, and at least one header credit has since come back;
- the last grant left less data credit than one maximum-size packet, and data credit has since come back.

Top module: `fcu_sched`

## Requirements
- R1: While and just after reset, `upd_valid` is 0 and `upd_idle` is 1. Without credit activity, no request appears before the update timer expires.
- R2: A credit free makes `upd_valid` rise on the second rising edge after the free is sampled. This applies when the last acknowledged update is older than the free and no urgency is pending. The request has `upd_hipri`=0, and its limits equal the current allocation: the configured capacity plus all credits freed, per class.
- R3: Suppose header credits consumed equal the last acknowledged header limit, so none remain, and a header credit is then freed. The resulting request carries `upd_hipri`=1.
- R4: Each acknowledge latches a shortfall flag for data. The flag is set when the acknowledged data limit minus data consumed is below one maximum payload in credits. One maximum payload is 8 << `cfg_mps` credits, where code 0 means 128 bytes and codes above 5 count as 5. A later data free while the flag is set produces a request with `upd_hipri`=1.
- R5: Suppose no credit is freed after an acknowledge. Then `upd_idle` falls TIMER_CYC edges after the acknowledge edge, and `upd_valid` rises one edge later with `upd_hipri`=1.
- R6: `upd_idle` is 0 while any urgency condition holds. This takes effect one edge after the pulse that completes the condition. It returns to 1 on the edge after the acknowledge that removes the condition.
- R7: While `upd_valid` is 1 and `upd_ready` is 0, `upd_valid`, `upd_hipri`, `upd_hdr_lim` and `upd_dat_lim` keep their values, even when credits are freed.
- R8: A handshake does four things: `upd_valid` drops for at least one cycle, the sent limits become the baseline, all urgency is cleared, and the timer restarts.
- R9: A class whose capacity is 0 at reset is unlimited. Its limit is advertised as 0, its use and free pulses are ignored, and it never raises urgency or a request.
- R10: Header counters wrap modulo 256 and data counters wrap modulo 4096. Starvation and release are still detected across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the capacities |
| cfg_hdr_cap | input | 8 | Header capacity sampled during reset (0 = unlimited) |
| cfg_dat_cap | input | 12 | Data capacity in 16-byte units sampled during reset (0 = unlimited) |
| cfg_mps | input | 3 | Maximum payload code, 128 << code bytes |
| hdr_use | input | 1 | One header credit consumed by an arriving packet |
| hdr_free | input | 1 | One header credit released by the consumer |
| dat_use_vld | input | 1 | Data credits consumed this cycle |
| dat_use_cnt | input | 6 | Number of data credits consumed |
| dat_free_vld | input | 1 | Data credits released this cycle |
| dat_free_cnt | input | 6 | Number of data credits released |
| upd_valid | output | 1 | Update request |
| upd_ready | input | 1 | Update taken when high together with `upd_valid` |
| upd_hipri | output | 1 | Request is urgent |
| upd_hdr_lim | output | 8 | Header limit to advertise |
| upd_dat_lim | output | 12 | Data limit to advertise |
| upd_idle | output | 1 | No urgent update pending |

## Verification
A sampled use or free pulse updates the counters on its edge. `upd_idle` reflects the new state after that same edge, and `upd_valid` after the next one. The timer request trails the acknowledge edge by TIMER_CYC edges for `upd_idle` and by TIMER_CYC+1 edges for `upd_valid`. The bench drives inputs at the falling edge and reads outputs at later falling edges, counted edge by edge against these latencies. It checks that a value has not yet changed one edge early, and that it has changed on the due edge. Request payloads are queued as they are predicted and compared at each handshake.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  localparam int HDR_W = 8;
  localparam int DAT_W = 12;
  localparam int MPS_W = 3;
  localparam int MPS_MAX_CODE = 5;
  localparam int MPS_BASE_CR = 8;   // 128 bytes in 16-byte units

  typedef enum logic [0:0] { TRK_LIVE = 1'b0, TRK_AT_ACK = 1'b1 } trk_mode_e;

  function automatic logic [DAT_W-1:0] mps_credits(input logic [MPS_W-1:0] code);
    logic [MPS_W-1:0] c;
    logic [DAT_W-1:0] r;
    c = (int'(code) > MPS_MAX_CODE) ? MPS_W'(MPS_MAX_CODE) : code;
    r = DAT_W'(MPS_BASE_CR) << c;
    return r;
  endfunction
endpackage

// File: rtl/fcu_credit_track.sv
module fcu_credit_track
  import fcu_pkg::*;
#(
  parameter int        W    = 8,
  parameter int        CW   = 1,
  parameter trk_mode_e MODE = TRK_LIVE
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cap,
  input  logic          use_vld,
  input  logic [CW-1:0] use_cnt,
  input  logic          free_vld,
  input  logic [CW-1:0] free_cnt,
  input  logic [W-1:0]  need,
  input  logic          ack,
  input  logic [W-1:0]  ack_lim,
  output logic [W-1:0]  alloc,
  output logic          freed,
  output logic          lack
);
  logic         inf_q;
  logic [W-1:0] cons_q, alloc_q, base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inf_q   <= (cap == '0);
      cons_q  <= '0;
      alloc_q <= cap;
      base_q  <= cap;
    end else begin
      if (!inf_q && use_vld)  cons_q  <= cons_q + W'(use_cnt);
      if (!inf_q && free_vld) alloc_q <= alloc_q + W'(free_cnt);
      if (ack)                base_q  <= ack_lim;
    end
  end

  assign alloc = alloc_q;
  assign freed = (alloc_q != base_q);

  generate
    if (MODE == TRK_LIVE) begin : g_live
      // remaining grant seen by the sender, re-evaluated every cycle
      logic [W-1:0] remain;
      assign remain = base_q - cons_q;
      assign lack   = !inf_q && (remain < need);
    end else begin : g_at_ack
      // grant judged once, when it is handed over
      logic         lack_q;
      logic [W-1:0] granted;
      assign granted = ack_lim - cons_q;
      always_ff @(posedge clk) begin
        if (!rst_n)   lack_q <= 1'b0;
        else if (ack) lack_q <= !inf_q && (granted < need);
      end
      assign lack = lack_q;
    end
  endgenerate
endmodule

// File: rtl/fcu_upd_timer.sv
module fcu_upd_timer #(
  parameter int TIMER_CYC = 4096
)(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int TW = $clog2(TIMER_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMER_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic          exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      exp_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = exp_q;
endmodule

// File: rtl/fcu_urgency.sv
module fcu_urgency (
  input  logic hdr_lack,
  input  logic hdr_freed,
  input  logic dat_lack,
  input  logic dat_freed,
  input  logic tmr_exp,
  output logic any_urg,
  output logic want
);
  logic hdr_urg, dat_urg, tmr_urg;

  assign hdr_urg = hdr_lack && hdr_freed;
  assign dat_urg = dat_lack && dat_freed;
  assign tmr_urg = tmr_exp && !hdr_freed && !dat_freed;
  assign any_urg = hdr_urg || dat_urg || tmr_urg;
  assign want    = any_urg || tmr_exp || hdr_freed || dat_freed;
endmodule

// File: rtl/fcu_sched.sv
module fcu_sched
  import fcu_pkg::*;
#(
  parameter int HDR_BITS  = fcu_pkg::HDR_W,
  parameter int DAT_BITS  = fcu_pkg::DAT_W,
  parameter int CNT_W     = 6,
  parameter int TIMER_CYC = 4096
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HDR_BITS-1:0] cfg_hdr_cap,
  input  logic [DAT_BITS-1:0] cfg_dat_cap,
  input  logic [MPS_W-1:0]    cfg_mps,
  input  logic                hdr_use,
  input  logic                hdr_free,
  input  logic                dat_use_vld,
  input  logic [CNT_W-1:0]    dat_use_cnt,
  input  logic                dat_free_vld,
  input  logic [CNT_W-1:0]    dat_free_cnt,
  output logic                upd_valid,
  input  logic                upd_ready,
  output logic                upd_hipri,
  output logic [HDR_BITS-1:0] upd_hdr_lim,
  output logic [DAT_BITS-1:0] upd_dat_lim,
  output logic                upd_idle
);
  localparam logic [HDR_BITS-1:0] HDR_NEED = HDR_BITS'(1);

  logic                ack;
  logic [HDR_BITS-1:0] hdr_alloc;
  logic [DAT_BITS-1:0] dat_alloc, dat_need;
  logic                hdr_freed, hdr_lack, dat_freed, dat_lack;
  logic                tmr_exp, any_urg, want;

  logic                valid_q, hipri_q;
  logic [HDR_BITS-1:0] hlim_q;
  logic [DAT_BITS-1:0] dlim_q;

  assign ack      = valid_q && upd_ready;
  assign dat_need = DAT_BITS'(mps_credits(cfg_mps));

  fcu_credit_track #(.W(HDR_BITS), .CW(1), .MODE(TRK_LIVE)) u_hdr (
    .clk(clk), .rst_n(rst_n), .cap(cfg_hdr_cap),
    .use_vld(hdr_use), .use_cnt(1'b1),
    .free_vld(hdr_free), .free_cnt(1'b1),
    .need(HDR_NEED), .ack(ack), .ack_lim(hlim_q),
    .alloc(hdr_alloc), .freed(hdr_freed), .lack(hdr_lack)
  );

  fcu_credit_track #(.W(DAT_BITS), .CW(CNT_W), .MODE(TRK_AT_ACK)) u_dat (
    .clk(clk), .rst_n(rst_n), .cap(cfg_dat_cap),
    .use_vld(dat_use_vld), .use_cnt(dat_use_cnt),
    .free_vld(dat_free_vld), .free_cnt(dat_free_cnt),
    .need(dat_need), .ack(ack), .ack_lim(dlim_q),
    .alloc(dat_alloc), .freed(dat_freed), .lack(dat_lack)
  );

  fcu_upd_timer #(.TIMER_CYC(TIMER_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(ack), .expired(tmr_exp)
  );

  fcu_urgency u_urg (
    .hdr_lack(hdr_lack), .hdr_freed(hdr_freed),
    .dat_lack(dat_lack), .dat_freed(dat_freed),
    .tmr_exp(tmr_exp), .any_urg(any_urg), .want(want)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hipri_q <= 1'b0;
      hlim_q  <= '0;
      dlim_q  <= '0;
    end else if (ack) begin
      valid_q <= 1'b0;
      hipri_q <= 1'b0;
    end else if (!valid_q && want) begin
      valid_q <= 1'b1;
      hipri_q <= any_urg;
      hlim_q  <= hdr_alloc;
      dlim_q  <= dat_alloc;
    end
  end

  assign upd_valid   = valid_q;
  assign upd_hipri   = hipri_q;
  assign upd_hdr_lim = hlim_q;
  assign upd_dat_lim = dlim_q;
  assign upd_idle    = !any_urg;
endmodule

// File: rtl/fcu_sched_chk.sv
module fcu_sched_chk #(
  parameter int HDR_BITS = 8,
  parameter int DAT_BITS = 12
)(
  input logic                clk,
  input logic                rst_n,
  input logic [HDR_BITS-1:0] cfg_hdr_cap,
  input logic                upd_valid,
  input logic                upd_ready,
  input logic                upd_hipri,
  input logic [HDR_BITS-1:0] upd_hdr_lim,
  input logic [DAT_BITS-1:0] upd_dat_lim,
  input logic                upd_idle
);
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_ready |=> upd_valid && $stable(upd_hipri) && $stable(upd_hdr_lim) && $stable(upd_dat_lim)); // R7

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_ready |=> !upd_valid); // R8

  AST_URGENT_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_valid) && upd_hipri |-> $past(!upd_idle)); // R6

  AST_PLAIN_WAS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_valid) && !upd_hipri |-> $past(upd_idle)); // R2

  AST_UNLIMITED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hdr_cap == '0) && upd_valid |-> (upd_hdr_lim == '0)); // R9
endmodule

bind fcu_sched fcu_sched_chk #(.HDR_BITS(HDR_BITS), .DAT_BITS(DAT_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_hdr_cap(cfg_hdr_cap),
  .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_hipri(upd_hipri),
  .upd_hdr_lim(upd_hdr_lim), .upd_dat_lim(upd_dat_lim), .upd_idle(upd_idle)
);

// File: tb/fcu_sched_tb.sv
`timescale 1ns/1ps
module fcu_sched_tb;
  localparam int P = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_hdr_cap = 8'd4;
  logic [11:0] cfg_dat_cap = 12'd32;
  logic [2:0]  cfg_mps = 3'd0;
  logic        hdr_use = 1'b0, hdr_free = 1'b0;
  logic        dat_use_vld = 1'b0, dat_free_vld = 1'b0;
  logic [5:0]  dat_use_cnt = '0, dat_free_cnt = '0;
  logic        upd_valid, upd_ready = 1'b0, upd_hipri, upd_idle;
  logic [7:0]  upd_hdr_lim;
  logic [11:0] upd_dat_lim;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  typedef struct { bit hp; int h; int d; string req; } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  fcu_sched #(.TIMER_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_hdr_cap(cfg_hdr_cap), .cfg_dat_cap(cfg_dat_cap),
    .cfg_mps(cfg_mps), .hdr_use(hdr_use), .hdr_free(hdr_free),
    .dat_use_vld(dat_use_vld), .dat_use_cnt(dat_use_cnt),
    .dat_free_vld(dat_free_vld), .dat_free_cnt(dat_free_cnt),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_hipri(upd_hipri),
    .upd_hdr_lim(upd_hdr_lim), .upd_dat_lim(upd_dat_lim), .upd_idle(upd_idle)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input bit hp, input int h, input int d, input string req);
    exp_t e;
    e.hp = hp; e.h = h; e.d = d; e.req = req;
    sbq.push_back(e);
  endtask

  // monitor: compare each handshake against the oldest prediction
  always @(negedge clk) begin
    #1;
    if (rst_n && upd_valid && upd_ready) begin
      if (sbq.size() == 0) chk("R8", "unexpected update", 1, 0);
      else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.req, "hipri", int'(upd_hipri), int'(e.hp));
        chk(e.req, "hdr_lim", int'(upd_hdr_lim), e.h);
        chk(e.req, "dat_lim", int'(upd_dat_lim), e.d);
      end
    end
  end

  task automatic nxt(); @(negedge clk); endtask

  task automatic do_reset(input int hcap, input int dcap);
    @(negedge clk);
    rst_n = 1'b0; cfg_hdr_cap = 8'(hcap); cfg_dat_cap = 12'(dcap);
    repeat (2) nxt();
    rst_n = 1'b1;
  endtask

  task automatic ack(); upd_ready = 1'b1; nxt(); upd_ready = 1'b0; endtask

  task automatic one_hfree(); hdr_free = 1'b1; nxt(); hdr_free = 1'b0; endtask

  task automatic pend(input string req, input bit hp, input int h, input int d);
    chk(req, "valid raised", int'(upd_valid), 1);
    chk(req, "hipri", int'(upd_hipri), int'(hp));
    push(hp, h, d, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    // reset state, header cap 4, data cap 32, 128-byte payload = 8 credits
    do_reset(4, 32);
    chk("R1", "valid after reset", int'(upd_valid), 0);
    chk("R1", "idle after reset", int'(upd_idle), 1);
    repeat (5) nxt();
    chk("R1", "no spontaneous request", int'(upd_valid), 0);

    // plain update after a header free, then hold under back-pressure
    one_hfree();                       // edge 1: alloc 5
    chk("R2", "not yet raised", int'(upd_valid), 0);
    nxt();                             // edge 2
    pend("R2", 1'b0, 5, 32);
    chk("R2", "hdr_lim", int'(upd_hdr_lim), 5);
    one_hfree();                       // alloc 6 while held
    for (int i = 0; i < 3; i++) begin
      nxt();
      chk("R7", "valid held", int'(upd_valid), 1);
      chk("R7", "hdr_lim frozen", int'(upd_hdr_lim), 5);
    end
    ack();
    chk("R8", "valid dropped after ack", int'(upd_valid), 0);
    nxt();
    pend("R2", 1'b0, 6, 32);           // second free now advertised
    ack();

    // header starvation then release
    hdr_use = 1'b1; repeat (6) nxt(); hdr_use = 1'b0;
    nxt();
    chk("R3", "starved but nothing freed: no request", int'(upd_valid), 0);
    chk("R6", "starved only: still idle", int'(upd_idle), 1);
    one_hfree();                       // alloc 7
    chk("R6", "idle drops on release", int'(upd_idle), 0);
    nxt();
    pend("R3", 1'b1, 7, 32);
    ack();
    chk("R6", "idle back after ack", int'(upd_idle), 1);

    // data shortfall: consume 30, free 4, ack leaves 6 < 8
    dat_use_vld = 1'b1; dat_use_cnt = 6'd30; nxt(); dat_use_vld = 1'b0;
    dat_free_vld = 1'b1; dat_free_cnt = 6'd4; nxt(); dat_free_vld = 1'b0;
    chk("R4", "room above one payload: idle", int'(upd_idle), 1);
    nxt();
    pend("R4", 1'b0, 7, 36);
    ack();
    nxt();
    chk("R4", "short but not released: idle", int'(upd_idle), 1);
    dat_free_vld = 1'b1; dat_free_cnt = 6'd1; nxt(); dat_free_vld = 1'b0;
    chk("R6", "idle drops on data release", int'(upd_idle), 0);
    nxt();
    pend("R4", 1'b1, 7, 37);
    ack();

    // timer expiry with nothing freed; ack edge was just before this point
    repeat (P - 1) nxt();
    chk("R5", "no request before expiry", int'(upd_valid), 0);
    chk("R5", "idle before expiry", int'(upd_idle), 1);
    nxt();
    chk("R5", "idle drops at expiry", int'(upd_idle), 0);
    chk("R5", "request one edge after expiry", int'(upd_valid), 0);
    nxt();
    pend("R5", 1'b1, 7, 37);
    ack();
    chk("R8", "timer urgency cleared", int'(upd_idle), 1);

    // unlimited header class
    do_reset(0, 32);
    hdr_use = 1'b1; repeat (3) nxt(); hdr_use = 1'b0;
    hdr_free = 1'b1; repeat (2) nxt(); hdr_free = 1'b0;
    repeat (3) nxt();
    chk("R9", "unlimited class: no request", int'(upd_valid), 0);
    chk("R9", "unlimited class: idle", int'(upd_idle), 1);
    dat_free_vld = 1'b1; dat_free_cnt = 6'd4; nxt(); dat_free_vld = 1'b0;
    nxt();
    pend("R9", 1'b0, 0, 36);
    chk("R9", "hdr_lim advertised 0", int'(upd_hdr_lim), 0);
    ack();

    // wrap of header counters
    do_reset(255, 32);
    one_hfree();                       // alloc 255+1 -> 0
    nxt();
    pend("R10", 1'b0, 0, 32);
    ack();
    hdr_use = 1'b1; repeat (256) nxt(); hdr_use = 1'b0;
    nxt();
    chk("R10", "wrapped starvation: idle until release", int'(upd_idle), 1);
    one_hfree();                       // alloc 1
    chk("R10", "idle drops on wrapped release", int'(upd_idle), 0);
    nxt();
    pend("R10", 1'b1, 1, 32);
    ack();

    repeat (3) nxt();
    chk("R8", "all predicted updates seen", sbq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule